// File: doc/BRIEF.md
# Prescaled Eight-Bit Timer with Interval, Overflow and PWM Modes

This block is an 8-bit timer/counter peripheral on a small synchronous register bus. It has three registers. A control register picks the count source and the operating mode, holds the two interrupt enables and the match-pending flag, and provides a one-shot counter clear. A data register holds the compare value. The third address returns the live counter and cannot be written. The counter advances once for each enable pulse. The pulse comes from one of three taps of a free-running 12-bit divider of the system clock (/8, /256, /4096) or from the rising edge of an external pin, which passes through a synchroniser first.

There are three modes. In interval mode the counter returns to zero on the count in which it equals the data register. In overflow mode the counter runs freely and wraps from 255 to 0. PWM mode runs like overflow mode and also drives a PWM pin, which stays high while the counter is below the data register. Two interrupt request lines leave the block. The match request comes from a flag that software clears. The overflow request is a pending bit that clears itself on an acknowledge or on a read of the control register.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0, and irq_match, irq_ovf and pwm_out are all 0. A control value of 0 selects the /4096 tap, interval mode, both enables off and no match pending.
- R2: Control bits [7:6] select the count source: 00 gives one count per 4096 clocks, 01 one per 256 clocks, 10 one per 8 clocks, 11 the external pin.
- R3: In external mode the pin passes through two synchronising flops. The counter gains exactly one count for each low-to-high transition, however long the pin stays high.
- R4: With control bits [5:4] = 00 (interval), a count event that finds the counter equal to the data register sets the counter to 0. No overflow is raised in this mode, even at 255.
- R5: With bits [5:4] = 01 or 10 (overflow), the counter increments on every count event and wraps from 255 to 0.
- R6: With bits [5:4] = 11 (PWM), the counter runs as in R5, and pwm_out is 1 exactly while the counter is below the data register. In every other mode pwm_out is 0.
- R7: A control write with bit 3 = 1 zeroes the counter on the next edge. This clear takes priority over a count event in the same cycle and suppresses that event's match and overflow. A write with bit 3 = 0 leaves the counter unchanged, and bit 3 always reads back 0.
- R8: Control bit 0 is the match flag. A count event that finds the counter equal to the data register sets it in every mode, whatever the match enable. A control write with bit 0 = 0 clears it, a write with bit 0 = 1 leaves it unchanged, and a match in the same cycle as a clearing write wins.
- R9: irq_match is 1 exactly when the match flag and the match enable (control bit 1) are both 1.
- R10: When control bit 2 is 1 and the counter wraps from 255 to 0 in overflow or PWM mode, a pending bit is set that drives irq_ovf. A pulse on ovf_ack clears it, and so does any read of the control register. A new wrap in the same cycle wins.
- R11: Address 0 is the control register and address 1 is the data register (read/write). Address 2 returns the counter, and writes to it are ignored. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the address |
| ext_clk_pin | input | 1 | Asynchronous external count input |
| ovf_ack | input | 1 | Acknowledge that clears the overflow request |
| irq_match | output | 1 | Match interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |
| pwm_out | output | 1 | PWM output pin |

## Verification
The properties assume the bus holds one access per cycle, with bus_sel qualifying bus_wr, bus_addr and bus_wdata. The mode field used in a cycle is taken as the registered value, so a control write changes counting behaviour only from the next edge. The external pin is assumed to stay at each level for at least two clocks, and the bench keeps every external pulse four clocks high and four clocks low. The bench changes inputs only on falling edges and reads only between accesses, so every property sees a clean single-cycle strobe.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      CK_SLOW = 2'b00,
      CK_MID  = 2'b01,
      CK_FAST = 2'b10,
      CK_EXT  = 2'b11
   } clk_sel_e;

   typedef enum logic [1:0] {
      MD_INTERVAL = 2'b00,
      MD_FREE_A   = 2'b01,
      MD_FREE_B   = 2'b10,
      MD_PWM      = 2'b11
   } mode_e;

   typedef struct packed {
      clk_sel_e clk_sel;
      mode_e    mode;
      logic     ovf_en;
      logic     match_en;
   } ctrl_t;

   localparam int unsigned ADDR_CTRL = 0;
   localparam int unsigned ADDR_DATA = 1;
   localparam int unsigned ADDR_CNT  = 2;

   localparam int unsigned CTRL_W = 8;

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler #(
   parameter int unsigned PRE_W    = 12,
   parameter int unsigned TAP_FAST = 3,
   parameter int unsigned TAP_MID  = 8,
   parameter int unsigned TAP_SLOW = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   output logic [2:0] ticks
);

   localparam int unsigned NTAP = 3;
   localparam int unsigned TAP_LOG [NTAP] = '{TAP_SLOW, TAP_MID, TAP_FAST};

   logic [PRE_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      assign ticks[i] = &div_q[TAP_LOG[i]-1:0];
   end

endmodule

// File: rtl/ptmr_edge_sync.sv
module ptmr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);

   logic [STAGES:0] sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[STAGES-1:0], async_in};
      end
   end

   assign rise = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
   import ptmr_pkg::*;
#(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          clr,
   input  mode_e         mode,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] cnt,
   output logic          match_evt,
   output logic          ovf_evt,
   output logic          pwm_out
);

   localparam logic [DW-1:0] CNT_TOP = '1;

   logic [DW-1:0] cnt_q;
   logic          at_match;
   logic          at_top;
   logic          is_interval;
   logic          live_tick;

   assign at_match    = (cnt_q == data);
   assign at_top      = (cnt_q == CNT_TOP);
   assign is_interval = (mode == MD_INTERVAL);
   assign live_tick   = tick & ~clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (is_interval && at_match) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign match_evt = live_tick & at_match;
   assign ovf_evt   = live_tick & at_top & ~is_interval;
   assign pwm_out   = (mode == MD_PWM) && (cnt_q < data);
   assign cnt       = cnt_q;

endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic [DW-1:0] cnt,
   input  logic          match_evt,
   input  logic          ovf_evt,
   input  logic          ovf_ack,
   output ctrl_t         ctrl,
   output logic [DW-1:0] data,
   output logic          clr_pulse,
   output logic          match_flag,
   output logic          ovf_pend
);

   localparam logic [AW-1:0] A_CTRL = AW'(ADDR_CTRL);
   localparam logic [AW-1:0] A_DATA = AW'(ADDR_DATA);
   localparam logic [AW-1:0] A_CNT  = AW'(ADDR_CNT);

   ctrl_t         ctrl_q;
   logic [DW-1:0] data_q;
   logic          flag_q;
   logic          pend_q;
   logic          wr_ctrl;
   logic          wr_data;
   logic          rd_ctrl;
   logic [CTRL_W-1:0] ctrl_view;

   assign wr_ctrl = bus_sel &  bus_wr & (bus_addr == A_CTRL);
   assign wr_data = bus_sel &  bus_wr & (bus_addr == A_DATA);
   assign rd_ctrl = bus_sel & ~bus_wr & (bus_addr == A_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= ctrl_t'({bus_wdata[7:4], bus_wdata[2:1]});
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_data) begin
         data_q <= bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (match_evt) begin
         flag_q <= 1'b1;
      end else if (wr_ctrl && !bus_wdata[0]) begin
         flag_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else if (ovf_evt && ctrl_q.ovf_en) begin
         pend_q <= 1'b1;
      end else if (ovf_ack || rd_ctrl) begin
         pend_q <= 1'b0;
      end
   end

   assign ctrl_view = {ctrl_q.clk_sel, ctrl_q.mode, 1'b0,
                       ctrl_q.ovf_en, ctrl_q.match_en, flag_q};

   always_comb begin
      unique case (bus_addr)
         A_CTRL:  bus_rdata = DW'(ctrl_view);
         A_DATA:  bus_rdata = data_q;
         A_CNT:   bus_rdata = cnt;
         default: bus_rdata = '0;
      endcase
   end

   assign ctrl       = ctrl_q;
   assign data       = data_q;
   assign clr_pulse  = wr_ctrl & bus_wdata[3];
   assign match_flag = flag_q;
   assign ovf_pend   = pend_q;

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
   import ptmr_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned AW          = 2,
   parameter int unsigned PRE_W       = 12,
   parameter int unsigned TAP_FAST    = 3,
   parameter int unsigned TAP_MID     = 8,
   parameter int unsigned TAP_SLOW    = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_sel,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          ext_clk_pin,
   input  logic          ovf_ack,
   output logic          irq_match,
   output logic          irq_ovf,
   output logic          pwm_out
);

   if (DW < CTRL_W) begin : g_bad_dw
      $error("prescaled_timer: DW must be at least the control width");
   end
   if (AW < 2) begin : g_bad_aw
      $error("prescaled_timer: AW must cover three registers");
   end
   if (TAP_FAST == 0 || TAP_FAST >= TAP_MID || TAP_MID >= TAP_SLOW
       || TAP_SLOW > PRE_W) begin : g_bad_tap
      $error("prescaled_timer: taps must rise strictly and fit the divider");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("prescaled_timer: at least two synchroniser stages needed");
   end

   logic [2:0]    pre_ticks;
   logic          ext_rise;
   logic [3:0]    tick_src;
   logic          count_en;
   ctrl_t         ctrl_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] cnt;
   logic          clr_pulse;
   logic          match_evt;
   logic          ovf_evt;
   logic          match_flag;
   logic          ovf_pend;

   ptmr_prescaler #(
      .PRE_W   (PRE_W),
      .TAP_FAST(TAP_FAST),
      .TAP_MID (TAP_MID),
      .TAP_SLOW(TAP_SLOW)
   ) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .ticks(pre_ticks)
   );

   ptmr_edge_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ext_clk_pin),
      .rise    (ext_rise)
   );

   assign tick_src = {ext_rise, pre_ticks};
   assign count_en = tick_src[ctrl_q.clk_sel];

   ptmr_core #(
      .DW(DW)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (count_en),
      .clr      (clr_pulse),
      .mode     (ctrl_q.mode),
      .data     (data_q),
      .cnt      (cnt),
      .match_evt(match_evt),
      .ovf_evt  (ovf_evt),
      .pwm_out  (pwm_out)
   );

   ptmr_regs #(
      .DW(DW),
      .AW(AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cnt       (cnt),
      .match_evt (match_evt),
      .ovf_evt   (ovf_evt),
      .ovf_ack   (ovf_ack),
      .ctrl      (ctrl_q),
      .data      (data_q),
      .clr_pulse (clr_pulse),
      .match_flag(match_flag),
      .ovf_pend  (ovf_pend)
   );

   assign irq_match = match_flag & ctrl_q.match_en;
   assign irq_ovf   = ovf_pend;

endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_sel,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_wdata,
   input logic [1:0]    mode,
   input logic          count_en,
   input logic          clr_pulse,
   input logic [DW-1:0] cnt,
   input logic [DW-1:0] data,
   input logic          match_evt,
   input logic          match_flag,
   input logic          irq_match,
   input logic          irq_ovf,
   input logic          pwm_out
);

   logic ctrl_wr;
   assign ctrl_wr = bus_sel & bus_wr & (bus_addr == '0);

   // R7
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (cnt == '0));

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !clr_pulse) |=> $stable(cnt));

   // R4
   interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00 && count_en && !clr_pulse && cnt == data) |=> (cnt == '0));

   // R8
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> $past(match_evt));

   // R8
   flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && bus_wdata[0] && match_flag) |=> match_flag);

   // R9
   irq_match_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_match |-> match_flag);

   // R6
   pwm_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out |-> (mode == 2'b11));

   // R10
   no_interval_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ovf) |-> $past(mode != 2'b00));

endmodule

bind prescaled_timer ptmr_chk #(
   .DW(DW),
   .AW(AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .mode      (ctrl_q.mode),
   .count_en  (count_en),
   .clr_pulse (clr_pulse),
   .cnt       (cnt),
   .data      (data_q),
   .match_evt (match_evt),
   .match_flag(match_flag),
   .irq_match (irq_match),
   .irq_ovf   (irq_ovf),
   .pwm_out   (pwm_out)
);

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       ext_clk_pin = 1'b0;
   logic       ovf_ack = 1'b0;
   logic       irq_match;
   logic       irq_ovf;
   logic       pwm_out;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   prescaled_timer u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .ext_clk_pin(ext_clk_pin),
      .ovf_ack    (ovf_ack),
      .irq_match  (irq_match),
      .irq_ovf    (irq_ovf),
      .pwm_out    (pwm_out)
   );

   typedef struct packed {
      logic [7:0] ctrl;
      logic [7:0] data;
      logic [7:0] pulses;
      logic [7:0] exp_cnt;
      logic       exp_flag;
      logic       exp_pwm;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VECS [NVEC] = '{
      '{8'hC8, 8'd5,   8'd3,  8'd3,  1'b0, 1'b0},
      '{8'hC8, 8'd5,   8'd6,  8'd0,  1'b1, 1'b0},
      '{8'hC8, 8'd2,   8'd7,  8'd1,  1'b1, 1'b0},
      '{8'hD8, 8'd200, 8'd10, 8'd10, 1'b0, 1'b0},
      '{8'hE8, 8'd3,   8'd5,  8'd5,  1'b1, 1'b0},
      '{8'hF8, 8'd4,   8'd2,  8'd2,  1'b0, 1'b1},
      '{8'hF8, 8'd4,   8'd6,  8'd6,  1'b1, 1'b0},
      '{8'hF8, 8'd0,   8'd1,  8'd1,  1'b1, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic ext_pulses(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         ext_clk_pin = 1'b1;
         repeat (4) @(negedge clk);
         ext_clk_pin = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic rate_window(input logic [7:0] ctrl, input int cycles, input logic [7:0] exp);
      logic [7:0] a;
      logic [7:0] b;
      bus_write(2'd0, ctrl);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
      #1 a = bus_rdata;
      repeat (cycles) @(negedge clk);
      #1 b = bus_rdata;
      bus_sel = 1'b0;
      check("R2 count rate", b - a, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(2'd0, rd); check("R1 control after reset", rd, 8'h00);
      bus_read(2'd2, rd); check("R1 counter after reset", rd, 8'h00);
      check("R1 irq_match after reset", irq_match, 1'b0);
      check("R1 irq_ovf after reset", irq_ovf, 1'b0);
      check("R1 pwm_out after reset", pwm_out, 1'b0);

      // R4 R5 R6 R8: vector table, external count source
      for (int v = 0; v < NVEC; v++) begin
         bus_write(2'd1, VECS[v].data);
         bus_write(2'd0, VECS[v].ctrl);
         ext_pulses(int'(VECS[v].pulses));
         bus_read(2'd2, rd);
         check($sformatf("R4/R5 vector %0d counter", v), rd, VECS[v].exp_cnt);
         bus_read(2'd0, rd);
         check($sformatf("R8 vector %0d match flag", v), rd[0], VECS[v].exp_flag);
         @(negedge clk);
         check($sformatf("R6 vector %0d pwm", v), pwm_out, VECS[v].exp_pwm);
      end

      // R7 write of 0 to clear bit has no effect, bit reads 0
      bus_write(2'd1, 8'd50);
      bus_write(2'd0, 8'hD8);
      ext_pulses(3);
      bus_write(2'd0, 8'hD0);
      bus_read(2'd2, rd); check("R7 clear bit 0 keeps counter", rd, 8'd3);
      bus_read(2'd0, rd); check("R7 clear bit reads 0", rd, 8'hD0);
      bus_write(2'd0, 8'hD8);
      bus_read(2'd2, rd); check("R7 clear bit 1 zeroes counter", rd, 8'd0);

      // R8 R9 flag with enable off, write 1 ignored, write 0 clears
      bus_write(2'd1, 8'd1);
      bus_write(2'd0, 8'hD8);
      ext_pulses(2);
      @(negedge clk);
      check("R9 irq_match off while disabled", irq_match, 1'b0);
      bus_write(2'd0, 8'hD3);
      bus_read(2'd0, rd); check("R8 write 1 leaves flag", rd, 8'hD3);
      check("R9 irq_match with flag and enable", irq_match, 1'b1);
      bus_write(2'd0, 8'hD2);
      bus_read(2'd0, rd); check("R8 write 0 clears flag", rd, 8'hD2);
      check("R9 irq_match drops with flag", irq_match, 1'b0);

      // R10 overflow pending, ack and read clearing
      bus_write(2'd0, 8'hDC);
      ext_pulses(255);
      bus_read(2'd2, rd); check("R5 counter at top", rd, 8'd255);
      check("R10 no overflow before wrap", irq_ovf, 1'b0);
      ext_pulses(1);
      bus_read(2'd2, rd); check("R5 counter wraps to 0", rd, 8'd0);
      check("R10 overflow raised on wrap", irq_ovf, 1'b1);
      @(negedge clk); ovf_ack = 1'b1;
      @(negedge clk); ovf_ack = 1'b0;
      check("R10 ack clears overflow", irq_ovf, 1'b0);
      ext_pulses(256);
      check("R10 overflow raised again", irq_ovf, 1'b1);
      bus_read(2'd0, rd);
      @(negedge clk);
      check("R10 control read clears overflow", irq_ovf, 1'b0);
      bus_write(2'd0, 8'hD8);
      ext_pulses(256);
      check("R10 no overflow when disabled", irq_ovf, 1'b0);

      // R4 interval mode at 255 gives no overflow
      bus_write(2'd1, 8'd255);
      bus_write(2'd0, 8'hCC);
      ext_pulses(256);
      bus_read(2'd2, rd); check("R4 interval wraps at data", rd, 8'd0);
      check("R4 interval raises no overflow", irq_ovf, 1'b0);
      bus_read(2'd0, rd); check("R4 interval match flag", rd, 8'hC5);

      // R3 one count per rise even with a long high level
      bus_write(2'd0, 8'hD8);
      @(negedge clk); ext_clk_pin = 1'b1;
      repeat (20) @(negedge clk);
      ext_clk_pin = 1'b0;
      repeat (4) @(negedge clk);
      bus_read(2'd2, rd); check("R3 long high counts once", rd, 8'd1);

      // R11 map: counter not writable, address 3 zero, data readback
      bus_write(2'd0, 8'hD8);
      bus_write(2'd2, 8'h77);
      bus_read(2'd2, rd); check("R11 counter write ignored", rd, 8'd0);
      bus_read(2'd3, rd); check("R11 address 3 reads 0", rd, 8'd0);
      bus_read(2'd1, rd); check("R11 data readback", rd, 8'd255);
      check("R6 pwm low outside PWM mode", pwm_out, 1'b0);

      // R2 prescaler taps
      rate_window(8'h98, 64, 8'd8);
      rate_window(8'h58, 512, 8'd2);
      rate_window(8'h18, 4096, 8'd1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule